// File: doc/BRIEF.md
# Majority-Clocked Three-Register Keystream Generator

This block produces a bit-serial keystream from three linear feedback shift registers whose 64 bits together form the generator state. While it produces keystream, the registers step irregularly: on every cycle a register advances only if its clocking bit agrees with the majority of the three clocking bits, so two or three registers move on each cycle. Each keystream bit is the XOR of the three most significant bits after that cycle's step.

There are two ways to start it. A keyed start clears the registers and then clocks in a 64-bit key and a 22-bit frame counter, one bit per cycle, with every register stepping on each of those cycles. It follows this with 100 irregular warm-up steps whose output is thrown away, and then delivers 228 keystream bits, enough for one 114-bit block in each direction. A direct start copies a 64-bit state into the registers and begins keystream output on the next cycle. This second path is meant for search engines that walk through the state space without repeating the keyed set-up. When the last bit has been delivered, a one-cycle done pulse is raised and the state is frozen until the next start.

Top module: `kgen_top`

## Requirements
- R1: While `rst` is high, all three registers clear to zero, and `ks_valid`, `ks_bit` and `done` are low on the cycle after.
- R2: Register A is 19 bits long with feedback taps {13,16,17,18} and clocking bit 8. Register B is 22 bits long with taps {20,21} and clocking bit 10. Register C is 23 bits long with taps {7,20,21,22} and clocking bit 10. During warm-up and output, a register steps only when its clocking bit equals the majority of the three clocking bits; otherwise it holds its value.
- R3: `state_in` and `state_out` share one layout: A at [18:0], B at [40:19], C at [63:41]. One step moves every bit of a register one place toward its MSB and puts the XOR of the tap bits into bit 0.
- R4: A keyed start (`mode_direct`=0) clears all registers on the start edge. Over the next 86 cycles the block feeds `key_in[0]` to `key_in[63]` and then `frame_in[0]` to `frame_in[21]`. On each of these cycles all three registers step, and the fed bit is XORed into bit 0 of every register.
- R5: After the load, 100 irregular warm-up steps run with `ks_valid` low. The first keystream bit of a keyed start is therefore visible 187 cycles after the start edge.
- R6: `ks_bit` is the XOR of the three register MSBs taken after that cycle's step. `ks_valid` is high for exactly OUT_BITS (228) consecutive cycles per start.
- R7: A direct start (`mode_direct`=1) copies `state_in` into the registers on the start edge. The first keystream bit is visible on the next cycle.
- R8: `done` is high for exactly one cycle, the same cycle as the last valid bit. After that, `state_out` stays unchanged until the next start.
- R9: A `start` that arrives while a load, warm-up or output phase is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| mode_direct | input | 1 | 1: load `state_in` directly; 0: keyed start |
| key_in | input | 64 | Key, bit 0 fed first |
| frame_in | input | 22 | Frame counter, bit 0 fed first after the key |
| state_in | input | 64 | State for a direct start |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | `ks_bit` carries a keystream bit |
| done | output | 1 | One-cycle pulse with the last keystream bit |
| state_out | output | 64 | Current register contents |

## Verification
The hardest condition to reach from the ports is the set of stepping patterns in which one particular register is the odd one out and stands still. Whether that happens depends on three clocking bits deep inside a 64-bit state. A direct start reaches those bits deliberately: the bench loads chosen states, including all-zero and all-one states and a state in which only one clocking bit differs. It also runs keyed starts whose load and warm-up walk through the patterns naturally. A behavioural model predicts every bit and the final state. One keyed run sends extra start pulses during the load and output phases, to show that they are ignored.

// File: rtl/kgen_pkg.sv
package kgen_pkg;

  localparam int NREG    = 3;
  localparam int STATE_W = 64;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_WARM = 2'd2,
    PH_RUN  = 2'd3
  } phase_t;

  function automatic int reg_len(input int i);
    case (i)
      0:       return 19;
      1:       return 22;
      default: return 23;
    endcase
  endfunction

  function automatic int reg_off(input int i);
    case (i)
      0:       return 0;
      1:       return 19;
      default: return 41;
    endcase
  endfunction

  function automatic int clk_pos(input int i);
    return (i == 0) ? 8 : 10;
  endfunction

  function automatic logic [31:0] fb_mask(input int i);
    case (i)
      0:       return 32'h0007_2000;
      1:       return 32'h0030_0000;
      default: return 32'h0070_0080;
    endcase
  endfunction

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/kgen_lfsr.sv
module kgen_lfsr #(
  parameter int             LEN     = 19,
  parameter int             CLK_POS = 8,
  parameter logic [LEN-1:0] TAPS    = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           ld,
  input  logic [LEN-1:0] ld_val,
  input  logic           adv,
  input  logic           inj,
  output logic [LEN-1:0] q,
  output logic           clk_bit,
  output logic           msb_next
);

  logic [LEN-1:0] nxt;
  logic           fb;

  assign fb = ^(q & TAPS);

  always_comb begin
    nxt = q;
    if (clr) begin
      nxt = '0;
    end else if (ld) begin
      nxt = ld_val;
    end else if (adv) begin
      nxt    = {q[LEN-2:0], fb};
      nxt[0] = fb ^ inj;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign clk_bit  = q[CLK_POS];
  assign msb_next = nxt[LEN-1];

endmodule

// File: rtl/kgen_ctrl.sv
module kgen_ctrl #(
  parameter int LOAD_LEN = 86,
  parameter int WARM_LEN = 100,
  parameter int OUT_LEN  = 228,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                mode_direct,
  output kgen_pkg::phase_t    phase,
  output logic [CNT_W-1:0]    cnt,
  output logic                clr,
  output logic                ld,
  output logic                reg_all,
  output logic                irr,
  output logic                emit,
  output logic                last
);
  import kgen_pkg::*;

  logic idle_go;

  assign idle_go = (phase == PH_IDLE) && start;
  assign clr     = idle_go && !mode_direct;
  assign ld      = idle_go && mode_direct;
  assign reg_all = (phase == PH_LOAD);
  assign irr     = (phase == PH_WARM) || (phase == PH_RUN);
  assign emit    = (phase == PH_RUN);
  assign last    = emit && (cnt == CNT_W'(OUT_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (start) phase <= mode_direct ? PH_RUN : PH_LOAD;
        end
        PH_LOAD: begin
          if (cnt == CNT_W'(LOAD_LEN - 1)) begin
            cnt   <= '0;
            phase <= PH_WARM;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_WARM: begin
          if (cnt == CNT_W'(WARM_LEN - 1)) begin
            cnt   <= '0;
            phase <= PH_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (last) begin
            cnt   <= '0;
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/kgen_top.sv
module kgen_top #(
  parameter int KEY_W       = 64,
  parameter int FRAME_W     = 22,
  parameter int WARM_CYCLES = 100,
  parameter int OUT_BITS    = 228
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        mode_direct,
  input  logic [KEY_W-1:0]            key_in,
  input  logic [FRAME_W-1:0]          frame_in,
  input  logic [kgen_pkg::STATE_W-1:0] state_in,
  output logic                        ks_bit,
  output logic                        ks_valid,
  output logic                        done,
  output logic [kgen_pkg::STATE_W-1:0] state_out
);
  import kgen_pkg::*;

  localparam int SEED_W = KEY_W + FRAME_W;
  localparam int SEL_W  = $clog2(SEED_W);
  localparam int CNT_W  = $clog2(max3(SEED_W, WARM_CYCLES, OUT_BITS) + 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             clr, ld, reg_all, irr, emit, last;

  kgen_ctrl #(
    .LOAD_LEN (SEED_W),
    .WARM_LEN (WARM_CYCLES),
    .OUT_LEN  (OUT_BITS),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .mode_direct (mode_direct),
    .phase       (phase),
    .cnt         (cnt),
    .clr         (clr),
    .ld          (ld),
    .reg_all     (reg_all),
    .irr         (irr),
    .emit        (emit),
    .last        (last)
  );

  logic [SEED_W-1:0] seed;
  logic              seed_bit;

  assign seed     = {frame_in, key_in};
  assign seed_bit = reg_all ? seed[SEL_W'(cnt)] : 1'b0;

  logic [NREG-1:0] cbit, adv, msb_n;
  logic            maj;

  assign maj = maj3(cbit);

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    localparam int L   = reg_len(gi);
    localparam int OFF = reg_off(gi);
    logic [L-1:0] q;

    assign adv[gi] = reg_all | (irr & (cbit[gi] == maj));

    kgen_lfsr #(
      .LEN     (L),
      .CLK_POS (clk_pos(gi)),
      .TAPS    (L'(fb_mask(gi)))
    ) u_reg (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr),
      .ld       (ld),
      .ld_val   (state_in[OFF +: L]),
      .adv      (adv[gi]),
      .inj      (seed_bit),
      .q        (q),
      .clk_bit  (cbit[gi]),
      .msb_next (msb_n[gi])
    );

    assign state_out[OFF +: L] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ks_bit   <= 1'b0;
      ks_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      ks_valid <= emit;
      ks_bit   <= emit & (^msb_n);
      done     <= last;
    end
  end

endmodule

// File: rtl/kgen_chk.sv
module kgen_chk (
  input logic                         clk,
  input logic                         rst,
  input logic                         start,
  input logic                         ks_valid,
  input logic                         done,
  input logic [kgen_pkg::STATE_W-1:0] state_out,
  input kgen_pkg::phase_t             phase
);
  import kgen_pkg::*;

  logic stepping, a_odd, c_odd;

  assign stepping = (phase == PH_WARM) || (phase == PH_RUN);
  assign a_odd = ($countones({state_out[8], state_out[29], state_out[51]}) >= 2) != state_out[8];
  assign c_odd = ($countones({state_out[8], state_out[29], state_out[51]}) >= 2) != state_out[51];

  // R1: reset clears everything on the following cycle
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!ks_valid && !done && state_out == '0));

  // R2: a register whose clocking bit is in the minority holds
  a_r2_a_holds: assert property (@(posedge clk) disable iff (rst)
    (stepping && a_odd) |=> (state_out[18:0] == $past(state_out[18:0])));

  a_r2_c_holds: assert property (@(posedge clk) disable iff (rst)
    (stepping && c_odd) |=> (state_out[63:41] == $past(state_out[63:41])));

  // R2 R3: a register in the majority moves toward its MSB
  a_r3_a_shifts: assert property (@(posedge clk) disable iff (rst)
    (stepping && !a_odd) |=> (state_out[18:1] == $past(state_out[17:0])));

  // R8: done is a single-cycle pulse aligned with the last bit
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_with_valid: assert property (@(posedge clk) disable iff (rst)
    done |-> ks_valid);

  // R8: state frozen while idle without start
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !start) |=> $stable(state_out));

endmodule

bind kgen_top kgen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .ks_valid  (ks_valid),
  .done      (done),
  .state_out (state_out),
  .phase     (phase)
);

// File: tb/test_kgen_top.sv
`timescale 1ns/1ps
module test_kgen_top;

  localparam int NOUT  = 228;
  localparam int KEYED_FIRST = 187;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode_direct = 1'b0;
  logic [63:0] key_in = '0;
  logic [21:0] frame_in = '0;
  logic [63:0] state_in = '0;
  logic        ks_bit, ks_valid, done;
  logic [63:0] state_out;

  always #2.5 clk = ~clk;

  kgen_top i_kgen_top (
    .clk(clk), .rst(rst), .start(start), .mode_direct(mode_direct),
    .key_in(key_in), .frame_in(frame_in), .state_in(state_in),
    .ks_bit(ks_bit), .ks_valid(ks_valid), .done(done), .state_out(state_out)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  bit          exp_q[$];
  logic [18:0] ma;
  logic [21:0] mb;
  logic [22:0] mc;
  logic [63:0] exp_final;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural model of one clock of the registers
  task automatic m_clock(input bit all, input bit inj);
    int  votes;
    bit  m, fa, fb, fc;
    votes = int'(ma[8]) + int'(mb[10]) + int'(mc[10]);
    m  = (votes >= 2);
    fa = ma[13] ^ ma[16] ^ ma[17] ^ ma[18];
    fb = mb[20] ^ mb[21];
    fc = mc[7] ^ mc[20] ^ mc[21] ^ mc[22];
    if (all || ma[8] == m)  begin ma = {ma[17:0], fa}; ma[0] = ma[0] ^ inj; end
    if (all || mb[10] == m) begin mb = {mb[20:0], fb}; mb[0] = mb[0] ^ inj; end
    if (all || mc[10] == m) begin mc = {mc[21:0], fc}; mc[0] = mc[0] ^ inj; end
  endtask

  task automatic build(input bit direct, input logic [63:0] k,
                       input logic [21:0] f, input logic [63:0] st);
    exp_q.delete();
    if (direct) begin
      ma = st[18:0]; mb = st[40:19]; mc = st[63:41];
    end else begin
      ma = '0; mb = '0; mc = '0;
      for (int i = 0; i < 64; i++)  m_clock(1'b1, k[i]);
      for (int i = 0; i < 22; i++)  m_clock(1'b1, f[i]);
      for (int i = 0; i < 100; i++) m_clock(1'b0, 1'b0);
    end
    for (int i = 0; i < NOUT; i++) begin
      m_clock(1'b0, 1'b0);
      exp_q.push_back(ma[18] ^ mb[21] ^ mc[22]);
    end
    exp_final = {mc, mb, ma};
  endtask

  task automatic run_case(input string req, input bit direct, input logic [63:0] k,
                          input logic [21:0] f, input logic [63:0] st, input bit poke);
    int first;
    int vbad;
    int bbad;
    build(direct, k, f, st);
    first = direct ? 1 : KEYED_FIRST;
    vbad = 0; bbad = 0;
    @(negedge clk);
    mode_direct = direct; key_in = k; frame_in = f; state_in = st;
    start = 1'b1;
    @(negedge clk);
    for (int c = 0; c < first + NOUT + 4; c++) begin
      bit expv;
      expv = (c >= first) && (c < first + NOUT);
      if (c == 0 && direct)
        check(state_out == st, "R3 R7", "state after direct load", state_out, st);
      if (c == 0 && !direct)
        check(state_out == '0, "R4", "cleared on keyed start", state_out, '0);
      if (ks_valid !== expv) begin
        vbad++;
        check(1'b0, "R5 R6", $sformatf("ks_valid cycle %0d", c), 64'(ks_valid), 64'(expv));
      end
      if (expv && ks_valid && ks_bit !== exp_q[c - first]) begin
        bbad++;
        check(1'b0, "R2 R6", $sformatf("ks_bit index %0d", c - first),
              64'(ks_bit), 64'(exp_q[c - first]));
      end
      if (done !== (c == first + NOUT - 1))
        check(1'b0, "R8", $sformatf("done cycle %0d", c), 64'(done),
              64'(c == first + NOUT - 1));
      if (c == first)
        check(ks_valid === 1'b1, "R5 R7", "first bit latency", 64'(ks_valid), 64'd1);
      start = poke && (c == 5 || c == first + 10);
      @(negedge clk);
    end
    check(vbad == 0, "R6", "valid window", 64'(vbad), 64'd0);
    check(bbad == 0, req, "keystream stream", 64'(bbad), 64'd0);
    check(state_out == exp_final, req, "final state", state_out, exp_final);
    repeat (6) @(negedge clk);
    check(state_out == exp_final && !ks_valid && !done, "R8", "hold after done",
          state_out, exp_final);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(state_out == '0 && !ks_valid && !done && !ks_bit, "R1", "reset state",
          state_out, '0);
    rst = 1'b0;
    @(negedge clk);
    check(state_out == '0, "R1", "idle after reset", state_out, '0);

    run_case("R7", 1'b1, '0, '0, 64'h0, 1'b0);
    run_case("R2 R7", 1'b1, '0, '0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    // only register A's clocking bit set: A is the odd one out
    run_case("R2 R3", 1'b1, '0, '0, 64'h0000_0000_0000_0100, 1'b0);
    run_case("R2 R7", 1'b1, '0, '0, 64'hA5C3_19E7_4D2B_8F61, 1'b0);
    run_case("R4 R5", 1'b0, 64'h0123_4567_89AB_CDEF, 22'h134, '0, 1'b0);
    run_case("R4 R9", 1'b0, 64'hF00D_CAFE_1357_9BDF, 22'h3F_FFFF, '0, 1'b1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule